// File: doc/BRIEF.md
# Management Packet Steering Controller

This block decides where each classified incoming packet goes. The choices are a sideband management controller, a wake request (PME), or the host receive path. Routing depends on the device power state, on a receive-enable setting that the management controller owns, and on the match flags that the wake filters supply.

In the low-power states, a management packet with receive enabled goes straight to the management controller. When it goes there, no wake request is raised. In D0, a management packet first takes the host path and is marked pending. When the host returns it, the packet is forwarded to the management controller and counted.

The block also provides the management-side controls:
- A status read, which clears an active-low change alert.
- Receive enable and disable commands.
- A destructive forced-management mode. This mode aborts traffic, flushes pending state and closes the PCI access gate until a PCI reset.

Top module: `mgmt_pkt_steer`

## Requirements
- R1: In any power state other than D0 (pwr_state_i != 0), a management packet with receive enabled gives a one-cycle to_mgmt_o pulse in the cycle after pkt_valid_i is sampled. pme_o stays low for that packet, whatever the filter flags are.
- R2: In a low-power state with receive disabled, a management packet never reaches the management controller. It raises pme_o only when some filter has both its hit bit and its management bit set.
- R3: In a low-power state, a non-management packet raises pme_o in the following cycle only if at least one filter hit bit is set.
- R4: In D0 every packet gives a one-cycle host_o pulse and never raises pme_o. A management packet with receive enabled becomes pending.
- R5: A host_ret_i pulse while a packet is pending produces a to_mgmt_o pulse in the next cycle. The same edge increments rx_cnt_o and clears the pending state, so a second return produces nothing. Every to_mgmt_o pulse adds one to rx_cnt_o.
- R6: Commands are sampled when cmd_valid_i is high, with cmd_op_i set to 0 for a status read, 1 for receive enable, 2 for receive disable and 3 for force. Reset leaves receive disabled.
- R7: A change on pwr_state_i or link_up_i drives alert_n_o low from the next cycle. It stays low until a status read. If a change and a read are sampled on the same edge, the alert stays low.
- R8: A status read captures pwr_state_i and link_up_i into stat_pwr_o and stat_link_o, visible in the next cycle.
- R9: A force command sampled in nominal mode gives abort_o and flush_o a single-cycle pulse in the next cycle and discards any pending packet. A force command in forced mode gives no pulse.
- R10: In forced mode, pci_acc_en_o is low and stays low until pci_rst_i.
- R11: pci_rst_i returns the block to nominal mode, disables receive and clears the pending state.
- R12: rx_cnt_o saturates at all ones when SAT_CNT is 1.
- R13: After rst_n, all pulses and rx_cnt_o are zero, alert_n_o is high and pci_acc_en_o is high.

Defaults: 4 filters and a 32-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_rst_i | input | 1 | Synchronous PCI reset, active high |
| pwr_state_i | input | 2 | Device power state, 0 = D0 |
| link_up_i | input | 1 | Link status |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code (see R6) |
| pkt_valid_i | input | 1 | Classified packet strobe |
| pkt_mgmt_i | input | 1 | Packet is a management packet |
| filt_hit_i | input | NF | Per-filter match flags |
| filt_mgmt_i | input | NF | Per-filter management bit of the type setting |
| host_ret_i | input | 1 | Host has returned a packet |
| to_mgmt_o | output | 1 | Steer-to-management pulse |
| pme_o | output | 1 | Wake request pulse |
| host_o | output | 1 | Host path pulse |
| alert_n_o | output | 1 | Active-low status change alert |
| stat_pwr_o | output | 2 | Power state captured by last read |
| stat_link_o | output | 1 | Link status captured by last read |
| rx_cnt_o | output | CNT_W | Forwarded packet counter |
| abort_o | output | 1 | Transmit/receive abort pulse |
| flush_o | output | 1 | Receive buffer flush pulse |
| pci_acc_en_o | output | 1 | PCI access permitted |

## Verification
A status change and a status read can land on the same clock edge, and the change must win. The bench drives a new power state and a read command in the same cycle. It expects alert_n_o low, with the snapshot showing the new state, and a further read then releases the alert. A host return and a new management packet can also coincide in D0, and a PCI reset can arrive while a force is pending. The directed sequence checks the forced-mode effects and then the reset that clears them.

// File: rtl/mps_pkg.sv
package mps_pkg;
   typedef enum logic [1:0] {
      CMD_READ   = 2'd0,
      CMD_RX_ON  = 2'd1,
      CMD_RX_OFF = 2'd2,
      CMD_FORCE  = 2'd3
   } mps_cmd_e;

   typedef enum logic {
      MODE_NOMINAL = 1'b0,
      MODE_FORCED  = 1'b1
   } mps_mode_e;

   localparam int unsigned PWR_W = 2;
   localparam logic [PWR_W-1:0] PWR_D0 = '0;
endpackage

// File: rtl/mps_mode_ctrl.sv
module mps_mode_ctrl
   import mps_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pci_rst_i,
   input  logic cmd_valid_i,
   input  logic [1:0] cmd_op_i,
   output logic forced_o,
   output logic rx_en_o,
   output logic enter_o,
   output logic abort_o,
   output logic flush_o
);
   mps_mode_e mode_q;
   mps_cmd_e  op;
   logic      rx_en_q;
   logic      pulse_q;

   assign op      = mps_cmd_e'(cmd_op_i);
   assign enter_o = cmd_valid_i && (op == CMD_FORCE) &&
                    (mode_q == MODE_NOMINAL) && !pci_rst_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_NOMINAL;
         rx_en_q <= 1'b0;
         pulse_q <= 1'b0;
      end else if (pci_rst_i) begin
         mode_q  <= MODE_NOMINAL;
         rx_en_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= enter_o;
         if (enter_o)
            mode_q <= MODE_FORCED;
         if (cmd_valid_i && op == CMD_RX_ON)
            rx_en_q <= 1'b1;
         else if (cmd_valid_i && op == CMD_RX_OFF)
            rx_en_q <= 1'b0;
      end
   end

   assign forced_o = (mode_q == MODE_FORCED);
   assign rx_en_o  = rx_en_q;
   assign abort_o  = pulse_q;
   assign flush_o  = pulse_q;
endmodule

// File: rtl/mps_route.sv
module mps_route
   import mps_pkg::*;
#(
   parameter int unsigned NF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic [PWR_W-1:0] pwr_i,
   input  logic pkt_valid_i,
   input  logic pkt_mgmt_i,
   input  logic [NF-1:0] hit_i,
   input  logic [NF-1:0] mbit_i,
   input  logic rx_en_i,
   input  logic host_ret_i,
   input  logic discard_i,
   output logic fwd_o,
   output logic to_mgmt_o,
   output logic pme_o,
   output logic host_o
);
   logic low_pwr, direct, ret_fwd, set_pend, pme_d, host_d;
   logic pend_q, to_mgmt_q, pme_q, host_q;
   logic any_hit, mgmt_hit;

   assign low_pwr  = (pwr_i != PWR_D0);
   assign any_hit  = |hit_i;
   assign mgmt_hit = |(hit_i & mbit_i);

   assign direct   = pkt_valid_i && low_pwr && pkt_mgmt_i && rx_en_i;
   assign ret_fwd  = host_ret_i && pend_q && !discard_i;
   assign set_pend = pkt_valid_i && !low_pwr && pkt_mgmt_i && rx_en_i;
   assign host_d   = pkt_valid_i && !low_pwr;
   assign pme_d    = pkt_valid_i && low_pwr && !direct &&
                     (pkt_mgmt_i ? mgmt_hit : any_hit);
   assign fwd_o    = direct || ret_fwd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         to_mgmt_q <= 1'b0;
         pme_q     <= 1'b0;
         host_q    <= 1'b0;
      end else begin
         to_mgmt_q <= fwd_o;
         pme_q     <= pme_d;
         host_q    <= host_d;
         if (discard_i)
            pend_q <= 1'b0;
         else
            pend_q <= set_pend || (pend_q && !host_ret_i);
      end
   end

   assign to_mgmt_o = to_mgmt_q;
   assign pme_o     = pme_q;
   assign host_o    = host_q;
endmodule

// File: rtl/mps_alert.sv
module mps_alert
   import mps_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic [PWR_W-1:0] pwr_i,
   input  logic link_i,
   input  logic read_i,
   output logic alert_n_o,
   output logic [PWR_W-1:0] stat_pwr_o,
   output logic stat_link_o
);
   logic [PWR_W-1:0] pwr_q, snap_pwr_q;
   logic link_q, snap_link_q, alert_q, changed;

   assign changed = (pwr_i != pwr_q) || (link_i != link_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q       <= PWR_D0;
         link_q      <= 1'b0;
         alert_q     <= 1'b0;
         snap_pwr_q  <= PWR_D0;
         snap_link_q <= 1'b0;
      end else begin
         pwr_q  <= pwr_i;
         link_q <= link_i;
         if (changed)
            alert_q <= 1'b1;
         else if (read_i)
            alert_q <= 1'b0;
         if (read_i) begin
            snap_pwr_q  <= pwr_i;
            snap_link_q <= link_i;
         end
      end
   end

   assign alert_n_o   = ~alert_q;
   assign stat_pwr_o  = snap_pwr_q;
   assign stat_link_o = snap_link_q;
endmodule

// File: rtl/mps_stat_ctr.sv
module mps_stat_ctr #(
   parameter int unsigned W   = 32,
   parameter bit          SAT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};
   logic [W-1:0] cnt_q, cnt_d;

   generate
      if (SAT) begin : g_sat
         assign cnt_d = (inc_i && cnt_q != TOP) ? cnt_q + 1'b1 : cnt_q;
      end else begin : g_wrap
         assign cnt_d = inc_i ? cnt_q + 1'b1 : cnt_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/mgmt_pkt_steer.sv
module mgmt_pkt_steer
   import mps_pkg::*;
#(
   parameter int unsigned NF      = 4,
   parameter int unsigned CNT_W   = 32,
   parameter bit          SAT_CNT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pci_rst_i,
   input  logic [1:0] pwr_state_i,
   input  logic link_up_i,
   input  logic cmd_valid_i,
   input  logic [1:0] cmd_op_i,
   input  logic pkt_valid_i,
   input  logic pkt_mgmt_i,
   input  logic [NF-1:0] filt_hit_i,
   input  logic [NF-1:0] filt_mgmt_i,
   input  logic host_ret_i,
   output logic to_mgmt_o,
   output logic pme_o,
   output logic host_o,
   output logic alert_n_o,
   output logic [1:0] stat_pwr_o,
   output logic stat_link_o,
   output logic [CNT_W-1:0] rx_cnt_o,
   output logic abort_o,
   output logic flush_o,
   output logic pci_acc_en_o
);
   generate
      if (NF < 1 || NF > 64) begin : g_bad_nf
         $error("mgmt_pkt_steer: NF out of range");
      end
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
         $error("mgmt_pkt_steer: CNT_W out of range");
      end
   endgenerate

   logic forced, rx_en, enter, fwd, discard, rd;

   assign rd      = cmd_valid_i && (mps_cmd_e'(cmd_op_i) == CMD_READ);
   assign discard = pci_rst_i || enter;

   mps_mode_ctrl u_mode (
      .clk(clk), .rst_n(rst_n), .pci_rst_i(pci_rst_i),
      .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
      .forced_o(forced), .rx_en_o(rx_en), .enter_o(enter),
      .abort_o(abort_o), .flush_o(flush_o)
   );

   mps_route #(.NF(NF)) u_route (
      .clk(clk), .rst_n(rst_n), .pwr_i(pwr_state_i),
      .pkt_valid_i(pkt_valid_i), .pkt_mgmt_i(pkt_mgmt_i),
      .hit_i(filt_hit_i), .mbit_i(filt_mgmt_i), .rx_en_i(rx_en),
      .host_ret_i(host_ret_i), .discard_i(discard), .fwd_o(fwd),
      .to_mgmt_o(to_mgmt_o), .pme_o(pme_o), .host_o(host_o)
   );

   mps_alert u_alert (
      .clk(clk), .rst_n(rst_n), .pwr_i(pwr_state_i), .link_i(link_up_i),
      .read_i(rd), .alert_n_o(alert_n_o), .stat_pwr_o(stat_pwr_o),
      .stat_link_o(stat_link_o)
   );

   mps_stat_ctr #(.W(CNT_W), .SAT(SAT_CNT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(fwd), .cnt_o(rx_cnt_o)
   );

   assign pci_acc_en_o = !forced;
endmodule

// File: rtl/mps_chk.sv
module mps_chk #(
   parameter int unsigned CNT_W   = 32,
   parameter bit          SAT_CNT = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic pci_rst_i,
   input logic [1:0] pwr_state_i,
   input logic link_up_i,
   input logic pkt_valid_i,
   input logic pkt_mgmt_i,
   input logic rx_en,
   input logic forced,
   input logic to_mgmt_o,
   input logic pme_o,
   input logic host_o,
   input logic alert_n_o,
   input logic abort_o,
   input logic pci_acc_en_o,
   input logic [CNT_W-1:0] rx_cnt_o
);
   p_lp_steer_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_i && pkt_mgmt_i && rx_en && pwr_state_i != 2'd0)
      |=> (to_mgmt_o && !pme_o));

   p_no_pme_with_steer_r1: assert property (@(posedge clk) disable iff (!rst_n)
      to_mgmt_o |-> !pme_o);

   p_d0_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_i && pwr_state_i == 2'd0) |=> (host_o && !pme_o));

   p_alert_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (pwr_state_i != $past(pwr_state_i) ||
                        link_up_i != $past(link_up_i))) |=> !alert_n_o);

   p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);

   p_forced_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      forced |-> !pci_acc_en_o);

   p_forced_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (forced && !pci_rst_i) |=> forced);

   p_pci_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pci_rst_i |=> (!forced && !rx_en));

   generate
      if (SAT_CNT) begin : g_sat_chk
         p_cnt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_cnt_o == {CNT_W{1'b1}}) |=> (rx_cnt_o == {CNT_W{1'b1}}));
      end
   endgenerate

   p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !to_mgmt_o |-> $stable(rx_cnt_o));
endmodule

bind mgmt_pkt_steer mps_chk #(.CNT_W(CNT_W), .SAT_CNT(SAT_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .pci_rst_i(pci_rst_i),
   .pwr_state_i(pwr_state_i), .link_up_i(link_up_i),
   .pkt_valid_i(pkt_valid_i), .pkt_mgmt_i(pkt_mgmt_i),
   .rx_en(rx_en), .forced(forced), .to_mgmt_o(to_mgmt_o), .pme_o(pme_o),
   .host_o(host_o), .alert_n_o(alert_n_o), .abort_o(abort_o),
   .pci_acc_en_o(pci_acc_en_o), .rx_cnt_o(rx_cnt_o)
);

// File: tb/test_mgmt_pkt_steer.sv
`timescale 1ns/1ps
module test_mgmt_pkt_steer;
   localparam int NF = 4;
   localparam int CW = 4;

   logic clk = 1'b0, rst_n = 1'b0, pci_rst = 1'b0;
   logic [1:0] pwr = 2'd0;
   logic link = 1'b0, cmd_v = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic pkt_v = 1'b0, pkt_m = 1'b0, hret = 1'b0;
   logic [NF-1:0] hit = '0, mbit = '0;
   logic to_mgmt, pme, host, alert_n, stat_link, abort_p, flush_p, acc_en;
   logic [1:0] stat_pwr;
   logic [CW-1:0] cnt;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mgmt_pkt_steer #(.NF(NF), .CNT_W(CW), .SAT_CNT(1'b1)) i_mgmt_pkt_steer (
      .clk(clk), .rst_n(rst_n), .pci_rst_i(pci_rst), .pwr_state_i(pwr),
      .link_up_i(link), .cmd_valid_i(cmd_v), .cmd_op_i(cmd_op),
      .pkt_valid_i(pkt_v), .pkt_mgmt_i(pkt_m), .filt_hit_i(hit),
      .filt_mgmt_i(mbit), .host_ret_i(hret), .to_mgmt_o(to_mgmt),
      .pme_o(pme), .host_o(host), .alert_n_o(alert_n),
      .stat_pwr_o(stat_pwr), .stat_link_o(stat_link), .rx_cnt_o(cnt),
      .abort_o(abort_p), .flush_o(flush_p), .pci_acc_en_o(acc_en)
   );

   // vector: pwr(2) rxen(1) mgmt(1) hit(4) mbit(4) | exp to_mgmt, pme, host
   localparam int NV = 8;
   localparam logic [14:0] VEC [NV] = '{
      {2'd3, 1'b1, 1'b1, 4'b0011, 4'b0001, 3'b100},  // R1 filters also hit
      {2'd3, 1'b0, 1'b1, 4'b0011, 4'b0001, 3'b010},  // R2 mgmt bit on hit
      {2'd3, 1'b0, 1'b1, 4'b0010, 4'b0001, 3'b000},  // R2 mgmt bit not on hit
      {2'd3, 1'b1, 1'b0, 4'b0100, 4'b0000, 3'b010},  // R3 hit
      {2'd2, 1'b0, 1'b0, 4'b0000, 4'b0000, 3'b000},  // R3 no hit
      {2'd0, 1'b0, 1'b1, 4'b1111, 4'b1111, 3'b001},  // R4 D0 no pme
      {2'd1, 1'b1, 1'b1, 4'b0000, 4'b0000, 3'b100},  // R1 D1
      {2'd0, 1'b1, 1'b0, 4'b0001, 4'b0000, 3'b001}   // R4 non-mgmt
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cmd(input logic [1:0] op);
      cmd_v = 1'b1; cmd_op = op;
      step();
      cmd_v = 1'b0;
   endtask

   task automatic pkt(input logic m, input logic [NF-1:0] h, input logic [NF-1:0] mb);
      pkt_v = 1'b1; pkt_m = m; hit = h; mbit = mb;
      step();
      pkt_v = 1'b0; pkt_m = 1'b0; hit = '0; mbit = '0;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13 pulses", {to_mgmt, pme, host, abort_p, flush_p}, 5'b0);
      chk("R13 alert_n/acc_en", {alert_n, acc_en}, 2'b11);
      chk("R13 count", cnt, 0);

      // table walk: R1 R2 R3 R4 R6
      for (int i = 0; i < NV; i++) begin
         pwr = VEC[i][14:13];
         cmd(VEC[i][12] ? 2'd1 : 2'd2);
         pkt(VEC[i][11], VEC[i][10:7], VEC[i][6:3]);
         chk($sformatf("R1/R2/R3/R4/R6 vector %0d", i),
             {to_mgmt, pme, host}, VEC[i][2:0]);
      end
      chk("R5 count after table", cnt, 2);

      // D0 round trip: R4 R5
      pwr = 2'd0;
      cmd(2'd1);
      pkt(1'b1, 4'b0001, 4'b0001);
      chk("R4 D0 mgmt to host", {to_mgmt, pme, host}, 3'b001);
      hret = 1'b1; step(); hret = 1'b0;
      chk("R5 return forwards", to_mgmt, 1);
      chk("R5 count incremented", cnt, 3);
      hret = 1'b1; step(); hret = 1'b0;
      chk("R5 second return ignored", {to_mgmt, cnt}, {1'b0, 4'd3});

      // alert: R7 R8
      cmd(2'd0);
      chk("R7 cleared by read", alert_n, 1);
      link = 1'b1; step();
      chk("R7 alert on link change", alert_n, 0);
      repeat (3) step();
      chk("R7 alert held", alert_n, 0);
      cmd(2'd0);
      chk("R7 read releases", alert_n, 1);
      chk("R8 snapshot", {stat_pwr, stat_link}, {2'd0, 1'b1});
      pwr = 2'd2; cmd(2'd0);
      chk("R7 change with read keeps alert", alert_n, 0);
      chk("R8 snapshot same edge", stat_pwr, 2'd2);
      cmd(2'd0);
      chk("R7 later read releases", alert_n, 1);

      // force mode: R9 R10
      pwr = 2'd0;
      pkt(1'b1, 4'b0000, 4'b0000);
      cmd(2'd3);
      chk("R9 abort/flush pulse", {abort_p, flush_p}, 2'b11);
      chk("R10 gate closed", acc_en, 0);
      step();
      chk("R9 pulse one cycle", {abort_p, flush_p}, 2'b00);
      hret = 1'b1; step(); hret = 1'b0;
      chk("R9 pending discarded", to_mgmt, 0);
      cmd(2'd3);
      chk("R9 no pulse when forced", abort_p, 0);
      repeat (5) step();
      chk("R10 gate stays closed", acc_en, 0);

      // pci reset: R11
      pci_rst = 1'b1; step(); pci_rst = 1'b0;
      chk("R11 gate reopened", acc_en, 1);
      pwr = 2'd3;
      pkt(1'b1, 4'b0001, 4'b0001);
      chk("R11 receive disabled", {to_mgmt, pme}, 2'b01);

      // saturation: R12
      cmd(2'd1);
      for (int k = 0; k < 20; k++) pkt(1'b1, 4'b0000, 4'b0000);
      chk("R12 count saturates", cnt, 4'hF);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule